// File: doc/BRIEF.md
# Flash Command Sequencer with Ready/Busy

This block sits behind the host bus of a NOR-style flash device. It watches host write cycles (chip enable, write enable, address and data) and walks the multi-cycle unlock sequences that start an embedded program or an embedded erase. While an embedded operation runs, it pulls the ready/busy line low. The line is open-drain, so several devices can share one net that a single resistor pulls high.

A parameterised countdown timer stands in for the duration of each embedded operation. An erase can be suspended, which frees the line, and then resumed. A hardware reset input aborts whatever is in progress and holds the line low for as long as it is asserted. Any command cycle that does not match the expected address and data returns the sequencer to read mode. Only the low data byte takes part in decoding.

Top module: `flash_cmd_seq`

## Requirements
- R1: After power-up reset the sequencer is in read mode (`read_mode`=1), `erase_held`=0 and `rb_pull_low`=0.
- R2: The program sequence is 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then any address and data. The low 11 address bits are compared. `rb_pull_low` stays 0 after the third write pulse and goes to 1 within four clock cycles after the rising edge of the fourth.
- R3: The erase sequence is 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, then a sixth cycle with data 0x30 at any address (sector erase) or data 0x10 at 0x555 (chip erase). The line stays released after the fifth write pulse and is pulled low after the sixth.
- R4: A program holds the line low for exactly PROG_TICKS clock cycles and an erase for exactly ERASE_TICKS clock cycles. Time spent suspended is not counted. Afterwards the line is released and `read_mode`=1.
- R5: While the line is held low, write cycles other than erase suspend are ignored. In particular, a complete new program or erase sequence neither extends the operation nor starts another one.
- R6: A cycle whose address or data does not match its step ends the sequence and returns to read mode. The cycles after it do not start an operation.
- R7: Data 0xB0 written during an erase releases the line and sets `erase_held`=1, and the erase timer stops. While suspended, any data other than 0x30 is ignored. Data 0x30 resumes the erase and pulls the line low again.
- R8: While `hw_reset_n` is 0, `rb_pull_low` is 1 in the same cycle. Any operation or partial sequence is dropped, and after release the block is ready in read mode.
- R9: With no operation running, the line is released (standby). Write-enable pulses while `ce_n` is high are ignored.
- R10: Data bits 15..8 are ignored in every command cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| hw_reset_n | input | 1 | Hardware reset pin, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; a cycle is taken on its rising edge |
| addr | input | ADDR_W | Host address |
| dq | input | 16 | Host data; only bits 7..0 are decoded |
| rb_pull_low | output | 1 | Drive-low enable for the open-drain ready/busy net |
| read_mode | output | 1 | Sequencer is idle in read mode |
| erase_held | output | 1 | Erase is suspended |

## Verification
The bench builds the block with PROG_TICKS=60 and ERASE_TICKS=150 instead of the long defaults. With these values, a full six-cycle erase sequence can be written while a program is still running, so the lockout can be seen directly. Drain waits stay short enough to run many sequences, and busy-cycle totals can be compared exactly across a suspend and resume. ADDR_W stays at 18, so the high address bits can carry values that the 11-bit unlock compare must ignore.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W      = 18,
  parameter int CMD_AW      = 11,
  parameter int PROG_TICKS  = 400,
  parameter int ERASE_TICKS = 2000,
  parameter logic [CMD_AW-1:0] UNLOCK_A = 11'h555,
  parameter logic [CMD_AW-1:0] UNLOCK_B = 11'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_reset_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq,
  output logic              rb_pull_low,
  output logic              read_mode,
  output logic              erase_held
);
  localparam int MAXT = (PROG_TICKS > ERASE_TICKS) ? PROG_TICKS : ERASE_TICKS;
  localparam int TW   = $clog2(MAXT + 1);

  localparam logic [3:0] S_READ  = 4'd0;
  localparam logic [3:0] S_UL1   = 4'd1;
  localparam logic [3:0] S_UL2   = 4'd2;
  localparam logic [3:0] S_PSET  = 4'd3;
  localparam logic [3:0] S_ESET  = 4'd4;
  localparam logic [3:0] S_EUL1  = 4'd5;
  localparam logic [3:0] S_EUL2  = 4'd6;
  localparam logic [3:0] S_PBUSY = 4'd7;
  localparam logic [3:0] S_EBUSY = 4'd8;
  localparam logic [3:0] S_SUSP  = 4'd9;

  logic [2:0]    we_sh;
  logic [1:0]    ce_sh;
  logic [3:0]    state;
  logic [TW-1:0] timer;
  logic          wr_stb;
  logic          hit_a, hit_b;
  logic [7:0]    cd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_sh <= '1;
      ce_sh <= '1;
    end else begin
      we_sh <= {we_sh[1:0], we_n};
      ce_sh <= {ce_sh[0], ce_n};
    end
  end

  assign wr_stb = we_sh[1] & ~we_sh[2] & ~ce_sh[1];
  assign cd     = dq[7:0];
  assign hit_a  = addr[CMD_AW-1:0] == UNLOCK_A;
  assign hit_b  = addr[CMD_AW-1:0] == UNLOCK_B;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_READ;
      timer <= '0;
    end else if (!hw_reset_n) begin
      state <= S_READ;
      timer <= '0;
    end else begin
      case (state)
        S_READ:  if (wr_stb && hit_a && cd == 8'hAA) state <= S_UL1;
        S_UL1:   if (wr_stb) state <= (hit_b && cd == 8'h55) ? S_UL2 : S_READ;
        S_UL2:
          if (wr_stb) begin
            if (hit_a && cd == 8'hA0)      state <= S_PSET;
            else if (hit_a && cd == 8'h80) state <= S_ESET;
            else                           state <= S_READ;
          end
        S_PSET:
          if (wr_stb) begin
            state <= S_PBUSY;
            timer <= TW'(PROG_TICKS - 1);
          end
        S_ESET:  if (wr_stb) state <= (hit_a && cd == 8'hAA) ? S_EUL1 : S_READ;
        S_EUL1:  if (wr_stb) state <= (hit_b && cd == 8'h55) ? S_EUL2 : S_READ;
        S_EUL2:
          if (wr_stb) begin
            if (cd == 8'h30 || (hit_a && cd == 8'h10)) begin
              state <= S_EBUSY;
              timer <= TW'(ERASE_TICKS - 1);
            end else begin
              state <= S_READ;
            end
          end
        S_PBUSY:
          if (timer == '0) state <= S_READ;
          else             timer <= timer - 1'b1;
        S_EBUSY:
          if (timer == '0) state <= S_READ;
          else begin
            timer <= timer - 1'b1;
            if (wr_stb && cd == 8'hB0) state <= S_SUSP;
          end
        S_SUSP:  if (wr_stb && cd == 8'h30) state <= S_EBUSY;
        default: state <= S_READ;
      endcase
    end
  end

  assign rb_pull_low = ~hw_reset_n | (state == S_PBUSY) | (state == S_EBUSY);
  assign read_mode   = state == S_READ;
  assign erase_held  = state == S_SUSP;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int TW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hw_reset_n,
  input logic          wr_stb,
  input logic [3:0]    state,
  input logic [TW-1:0] timer,
  input logic          rb_pull_low,
  input logic          erase_held
);
  localparam logic [3:0] C_READ  = 4'd0;
  localparam logic [3:0] C_PSET  = 4'd3;
  localparam logic [3:0] C_PBUSY = 4'd7;
  localparam logic [3:0] C_EBUSY = 4'd8;
  localparam logic [3:0] C_SUSP  = 4'd9;

  // R2
  prog_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_reset_n && state == C_PSET && wr_stb) |=> rb_pull_low);

  // R8
  hwrst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_reset_n |-> rb_pull_low);

  // R7
  susp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_reset_n && erase_held) |-> !rb_pull_low);

  // R7
  susp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_reset_n && state == C_SUSP && $past(state) == C_SUSP) |-> $stable(timer));

  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_reset_n && state == C_PBUSY) |=> (state == C_PBUSY || state == C_READ || !hw_reset_n));

  // R4
  expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_reset_n && (state == C_PBUSY || state == C_EBUSY) && timer == '0)
      |=> (!rb_pull_low || !hw_reset_n));

  // R9
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_reset_n && state == C_READ) |-> !rb_pull_low);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_reset_n(hw_reset_n), .wr_stb(wr_stb),
  .state(state), .timer(timer), .rb_pull_low(rb_pull_low), .erase_held(erase_held)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int PT = 60;
  localparam int ET = 150;

  logic clk = 0, rst_n = 0, hw_reset_n = 1, ce_n = 1, we_n = 1;
  logic [17:0] addr = '0;
  logic [15:0] dq = '0;
  logic rb_pull_low, read_mode, erase_held;
  wire  ryby = rb_pull_low ? 1'b0 : 1'b1;

  int checks = 0, failures = 0, lowcnt = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(negedge clk) if (ryby == 1'b0) lowcnt++;

  flash_cmd_seq #(.PROG_TICKS(PT), .ERASE_TICKS(ET)) dut (
    .clk(clk), .rst_n(rst_n), .hw_reset_n(hw_reset_n), .ce_n(ce_n), .we_n(we_n),
    .addr(addr), .dq(dq), .rb_pull_low(rb_pull_low), .read_mode(read_mode),
    .erase_held(erase_held));

  // {addr, data, expected pull-low, expected read_mode, drain: 0 none, 1 program, 2 erase}
  localparam int N = 30;
  localparam logic [37:0] TBL [N] = '{
    {18'h00555, 16'h00AA, 1'b0, 1'b0, 2'd0},
    {18'h002AA, 16'h0055, 1'b0, 1'b0, 2'd0},
    {18'h00555, 16'h00A0, 1'b0, 1'b0, 2'd0},
    {18'h01234, 16'h00AB, 1'b1, 1'b0, 2'd1},
    {18'h00555, 16'h00AA, 1'b0, 1'b0, 2'd0},
    {18'h002AA, 16'h0055, 1'b0, 1'b0, 2'd0},
    {18'h00555, 16'h0080, 1'b0, 1'b0, 2'd0},
    {18'h00555, 16'h00AA, 1'b0, 1'b0, 2'd0},
    {18'h002AA, 16'h0055, 1'b0, 1'b0, 2'd0},
    {18'h3F000, 16'h0030, 1'b1, 1'b0, 2'd2},
    {18'h00555, 16'h00AA, 1'b0, 1'b0, 2'd0},
    {18'h00123, 16'h0055, 1'b0, 1'b1, 2'd0},
    {18'h00555, 16'h00A0, 1'b0, 1'b1, 2'd0},
    {18'h00000, 16'h0000, 1'b0, 1'b1, 2'd0},
    {18'h00555, 16'h00AA, 1'b0, 1'b0, 2'd0},
    {18'h002AA, 16'h0055, 1'b0, 1'b0, 2'd0},
    {18'h00555, 16'h0080, 1'b0, 1'b0, 2'd0},
    {18'h00555, 16'h00AA, 1'b0, 1'b0, 2'd0},
    {18'h002AA, 16'h0055, 1'b0, 1'b0, 2'd0},
    {18'h00555, 16'h0010, 1'b1, 1'b0, 2'd2},
    {18'h20555, 16'hFFAA, 1'b0, 1'b0, 2'd0},
    {18'h102AA, 16'h1255, 1'b0, 1'b0, 2'd0},
    {18'h00555, 16'h77A0, 1'b0, 1'b0, 2'd0},
    {18'h00000, 16'h0000, 1'b1, 1'b0, 2'd1},
    {18'h00555, 16'h00AA, 1'b0, 1'b0, 2'd0},
    {18'h002AA, 16'h0055, 1'b0, 1'b0, 2'd0},
    {18'h00555, 16'h0080, 1'b0, 1'b0, 2'd0},
    {18'h00555, 16'h00AA, 1'b0, 1'b0, 2'd0},
    {18'h002AA, 16'h0055, 1'b0, 1'b0, 2'd0},
    {18'h00555, 16'h0077, 1'b0, 1'b1, 2'd0}
  };

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [17:0] a, logic [15:0] d, logic ce = 1'b0);
    @(negedge clk);
    addr = a; dq = d; ce_n = ce; we_n = 0;
    repeat (2) @(negedge clk);
    we_n = 1;
    repeat (4) @(negedge clk);
    ce_n = 1;
    @(negedge clk);
  endtask

  task automatic prog_seq(logic [17:0] a);
    wr(18'h555, 16'hAA); wr(18'h2AA, 16'h55); wr(18'h555, 16'hA0); wr(a, 16'h1234);
  endtask

  task automatic erase_seq();
    wr(18'h555, 16'hAA); wr(18'h2AA, 16'h55); wr(18'h555, 16'h80);
    wr(18'h555, 16'hAA); wr(18'h2AA, 16'h55); wr(18'h1000, 16'h30);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 read_mode", read_mode, 1);
    check("R1 erase_held", erase_held, 0);
    check("R1 ryby", ryby, 1);

    // R2 R3 R6 R10 table
    for (int i = 0; i < N; i++) begin
      wr(TBL[i][37:20], TBL[i][19:4]);
      check($sformatf("R2/R3/R6/R10 row %0d busy", i), rb_pull_low, TBL[i][3]);
      check($sformatf("R2/R3/R6/R10 row %0d read_mode", i), read_mode, TBL[i][2]);
      if (TBL[i][1:0] != 0) begin
        repeat ((TBL[i][1:0] == 1 ? PT : ET) + 2) @(negedge clk);
        check($sformatf("R4 row %0d released", i), ryby, 1);
        check($sformatf("R4 row %0d read_mode", i), read_mode, 1);
      end
    end

    // R4 exact program duration
    lowcnt = 0;
    prog_seq(18'h44);
    repeat (PT + 5) @(negedge clk);
    check("R4 program low cycles", lowcnt, PT);

    // R5 commands ignored while busy
    lowcnt = 0;
    prog_seq(18'h45);
    erase_seq();
    wr(18'h555, 16'hAA);
    repeat (PT + 5) @(negedge clk);
    check("R5 busy length unchanged", lowcnt, PT);
    check("R5 read_mode after", read_mode, 1);
    repeat (20) @(negedge clk);
    check("R5 no late operation", ryby, 1);

    // R7 suspend and resume
    lowcnt = 0;
    erase_seq();
    repeat (20) @(negedge clk);
    wr(18'h0, 16'hB0);
    check("R7 released on suspend", ryby, 1);
    check("R7 erase_held", erase_held, 1);
    repeat (ET + 20) @(negedge clk);
    check("R7 still suspended", erase_held, 1);
    wr(18'h555, 16'h55A0);
    check("R7 non-resume ignored", erase_held, 1);
    check("R7 ryby high in suspend", ryby, 1);
    wr(18'h0, 16'h0030);
    check("R7 resumed busy", ryby, 0);
    check("R7 erase_held cleared", erase_held, 0);
    repeat (ET + 5) @(negedge clk);
    check("R4/R7 erase low cycles", lowcnt, ET);
    check("R7 read_mode after", read_mode, 1);

    // R8 hardware reset
    hw_reset_n = 0;
    #1;
    check("R8 low while idle", ryby, 0);
    @(negedge clk);
    hw_reset_n = 1;
    @(negedge clk);
    check("R8 released idle", ryby, 1);
    prog_seq(18'h46);
    repeat (10) @(negedge clk);
    hw_reset_n = 0;
    #1;
    check("R8 low immediately", ryby, 0);
    repeat (PT + 20) @(negedge clk);
    check("R8 still low held", ryby, 0);
    hw_reset_n = 1;
    repeat (2) @(negedge clk);
    check("R8 ready after release", ryby, 1);
    check("R8 read_mode after release", read_mode, 1);
    wr(18'h555, 16'hAA); wr(18'h2AA, 16'h55);
    hw_reset_n = 0;
    repeat (2) @(negedge clk);
    hw_reset_n = 1;
    wr(18'h555, 16'hA0); wr(18'h10, 16'h10);
    check("R8 partial sequence dropped", ryby, 1);

    // R9 standby and ce_n high
    wr(18'h555, 16'hAA, 1'b1); wr(18'h2AA, 16'h55, 1'b1);
    wr(18'h555, 16'hA0, 1'b1); wr(18'h10, 16'h10, 1'b1);
    check("R9 writes with ce high ignored", ryby, 1);
    check("R9 read_mode", read_mode, 1);
    repeat (10) @(negedge clk);
    check("R9 standby ready", ryby, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule